// File: doc/BRIEF.md
# Cartridge ROM Bank-Select Controller

This block holds the bank-switching logic of a multi-game ROM cartridge for a 6502 home computer. The ROM is split into 8 KB cells, and an 8-bit cell number picks one of them. There are two cell registers, and they share one set of upper ROM address lines. One register maps the low expansion blocks, which hold 8 KB and 16 KB games. The other maps the autostart block at $A000. A register drives the shared lines only while its own block is being accessed. When no block is selected, the lines rest at zero and the ROM enables are inactive.

Software loads a register by writing a cell number to one of two I/O strobes. The low-block register is loaded through the second strobe and the autostart register through the third. Reset clears an enable flag. While that flag is clear, any autostart-block access is forced to a fixed menu cell, so the machine always finds the menu's autostart code after power-up. The first write to the autostart register sets the flag. The low-block register has no reset, because its value before the first write is never used.

For 16 KB games the lowest bit of the upper ROM address is the CPU's A13 XORed with bit 0 of the cell number. A cell pair therefore appears as one contiguous 16 KB image. A parameter can turn this folding off.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset, and until the first write to the autostart register, an autostart-block access (blk5_ni low) drives rom_hi_o to MENU_CELL.
- R2: A write with rw_i low and io3_ni low at a rising clock edge loads data_i into the autostart register and sets the enable flag. From then on, autostart-block accesses drive that value on rom_hi_o, and a written value of 0 is used as is.
- R3: A write with rw_i low and io2_ni low at a rising clock edge loads data_i into the low-block register. An access through blk1_ni, blk2_ni or blk3_ni then drives that value on rom_hi_o, with bit 0 replaced by bit 0 XOR a13_i.
- R4: When rw_i is high, a strobe (io2_ni or io3_ni low) changes neither register, and the data bus is never driven by the block.
- R5: With no block select low, rom_hi_o is 0, rom_ce_no is 1 and rom_oe_no is 1.
- R6: rom_ce_no is low exactly when some block select is low. rom_oe_no is low only when a block select is low and rw_i is high.
- R7: An autostart-block access shows only the autostart register. If blk5_ni and a low-block select are both low, the autostart mapping wins.
- R8: A reset after loading returns autostart accesses to MENU_CELL but leaves the low-block register unchanged. A later io3 write re-enables the written cell.
- R9: A register write takes effect only at the clock edge. During the write cycle, rom_hi_o still shows the earlier mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU-phase clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | CELL_W | CPU data bus (input only) |
| rw_i | input | 1 | CPU read (1) / write (0) |
| io2_ni | input | 1 | Low-block register strobe, active low |
| io3_ni | input | 1 | Autostart register strobe, active low |
| blk1_ni | input | 1 | Low expansion block 1 select, active low |
| blk2_ni | input | 1 | Low expansion block 2 select, active low |
| blk3_ni | input | 1 | Low expansion block 3 select, active low |
| blk5_ni | input | 1 | Autostart block select, active low |
| a13_i | input | 1 | CPU address bit 13 |
| rom_hi_o | output | CELL_W | ROM address lines from A13 upward |
| rom_ce_no | output | 1 | ROM chip enable, active low |
| rom_oe_no | output | 1 | ROM output enable, active low |

## Verification
The bench builds the block with CELL_W = 8, the 16 KB folding enabled, and MENU_CELL = 3. With a non-zero menu cell, the reset fallback can be told apart from the idle value of zero and from a deliberate write of cell 0. With the folding enabled, both values of a13_i can be checked against one loaded low-block cell. An 8-bit width is enough to reach the all-ones and near-top cell numbers with little stimulus.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_LOW  = 2'd1,
    SRC_AUTO = 2'd2
  } map_src_e;
endpackage

// File: rtl/cell_reg.sv
module cell_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // no reset: contents are only used after software loads them
  always_ff @(posedge clk_i) begin
    if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/menu_enable.sv
module menu_enable (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  output logic en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_o <= 1'b0;
    else if (set_i) en_o <= 1'b1;
  end
endmodule

// File: rtl/rom_addr_mux.sv
module rom_addr_mux
  import cart_bank_pkg::*;
#(
  parameter int              W         = 8,
  parameter bit              FOLD_16K  = 1'b1,
  parameter logic [W-1:0]    MENU_CELL = '0
) (
  input  map_src_e     src_i,
  input  logic         auto_en_i,
  input  logic         a13_i,
  input  logic [W-1:0] low_cell_i,
  input  logic [W-1:0] auto_cell_i,
  output logic [W-1:0] hi_o
);
  logic [W-1:0] low_map;

  generate
    if (FOLD_16K) begin : g_fold
      if (W > 1) begin : g_wide
        assign low_map = {low_cell_i[W-1:1], low_cell_i[0] ^ a13_i};
      end else begin : g_narrow
        assign low_map = low_cell_i ^ a13_i;
      end
    end else begin : g_flat
      logic unused_a13;
      assign unused_a13 = a13_i;
      assign low_map    = low_cell_i;
    end
  endgenerate

  always_comb begin
    unique case (src_i)
      SRC_AUTO: hi_o = auto_en_i ? auto_cell_i : MENU_CELL;
      SRC_LOW:  hi_o = low_map;
      default:  hi_o = '0;
    endcase
  end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int           CELL_W    = 8,
  parameter bit           FOLD_16K  = 1'b1,
  parameter logic [CELL_W-1:0] MENU_CELL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CELL_W-1:0] data_i,
  input  logic              rw_i,
  input  logic              io2_ni,
  input  logic              io3_ni,
  input  logic              blk1_ni,
  input  logic              blk2_ni,
  input  logic              blk3_ni,
  input  logic              blk5_ni,
  input  logic              a13_i,
  output logic [CELL_W-1:0] rom_hi_o,
  output logic              rom_ce_no,
  output logic              rom_oe_no
);
  logic              wr_low, wr_auto;
  logic              sel_low, sel_auto, sel_any;
  logic              auto_en;
  logic [CELL_W-1:0] low_cell, auto_cell;
  map_src_e          src;

  assign wr_low   = !rw_i && !io2_ni;
  assign wr_auto  = !rw_i && !io3_ni;
  assign sel_low  = !(blk1_ni && blk2_ni && blk3_ni);
  assign sel_auto = !blk5_ni;
  assign sel_any  = sel_low || sel_auto;

  // autostart block has priority if selects overlap
  always_comb begin
    if (sel_auto)     src = SRC_AUTO;
    else if (sel_low) src = SRC_LOW;
    else              src = SRC_NONE;
  end

  cell_reg #(.W(CELL_W)) u_low_reg (
    .clk_i (clk_i),
    .load_i(wr_low),
    .d_i   (data_i),
    .q_o   (low_cell)
  );

  cell_reg #(.W(CELL_W)) u_auto_reg (
    .clk_i (clk_i),
    .load_i(wr_auto),
    .d_i   (data_i),
    .q_o   (auto_cell)
  );

  menu_enable u_menu_en (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (wr_auto),
    .en_o  (auto_en)
  );

  rom_addr_mux #(
    .W        (CELL_W),
    .FOLD_16K (FOLD_16K),
    .MENU_CELL(MENU_CELL)
  ) u_mux (
    .src_i      (src),
    .auto_en_i  (auto_en),
    .a13_i      (a13_i),
    .low_cell_i (low_cell),
    .auto_cell_i(auto_cell),
    .hi_o       (rom_hi_o)
  );

  assign rom_ce_no = !sel_any;
  assign rom_oe_no = !(sel_any && rw_i);
endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk #(
  parameter int                CELL_W    = 8,
  parameter logic [CELL_W-1:0] MENU_CELL = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CELL_W-1:0] data_i,
  input logic              rw_i,
  input logic              io2_ni,
  input logic              io3_ni,
  input logic              blk1_ni,
  input logic              blk2_ni,
  input logic              blk3_ni,
  input logic              blk5_ni,
  input logic [CELL_W-1:0] rom_hi_o,
  input logic              rom_ce_no,
  input logic              rom_oe_no
);
  logic seen_wr;
  logic any_sel;
  assign any_sel = !(blk1_ni && blk2_ni && blk3_ni && blk5_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 seen_wr <= 1'b0;
    else if (!rw_i && !io3_ni)   seen_wr <= 1'b1;
  end

  p_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_sel |-> (rom_hi_o == '0 && rom_ce_no && rom_oe_no));

  p_ce_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_ce_no == !any_sel);

  p_oe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rom_oe_no |-> (rw_i && any_sel));

  p_menu_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seen_wr && !blk5_ni) |-> rom_hi_o == MENU_CELL);

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rw_i && !io3_ni) |=> (!blk5_ni -> rom_hi_o == $past(data_i)));

  p_noread_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blk5_ni && $past(!blk5_ni) && $past(rst_ni) &&
     $past(rw_i || io3_ni)) |-> $stable(rom_hi_o));
endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk #(
  .CELL_W   (CELL_W),
  .MENU_CELL(MENU_CELL)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .data_i   (data_i),
  .rw_i     (rw_i),
  .io2_ni   (io2_ni),
  .io3_ni   (io3_ni),
  .blk1_ni  (blk1_ni),
  .blk2_ni  (blk2_ni),
  .blk3_ni  (blk3_ni),
  .blk5_ni  (blk5_ni),
  .rom_hi_o (rom_hi_o),
  .rom_ce_no(rom_ce_no),
  .rom_oe_no(rom_oe_no)
);

// File: tb/cart_bank_ctrl_bench.sv
module cart_bank_ctrl_bench;
  localparam int         W    = 8;
  localparam logic [7:0] MENU = 8'h03;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] data = '0;
  logic         rw = 1'b1, io2_n = 1'b1, io3_n = 1'b1;
  logic         b1_n = 1'b1, b2_n = 1'b1, b3_n = 1'b1, b5_n = 1'b1;
  logic         a13 = 1'b0;
  logic [W-1:0] hi;
  logic         ce_n, oe_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference state
  int m_low  = -1;
  int m_auto = 0;
  bit m_en   = 0;

  always #10 clk = ~clk;

  cart_bank_ctrl #(.CELL_W(W), .FOLD_16K(1'b1), .MENU_CELL(MENU)) u_cart_bank_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .rw_i(rw),
    .io2_ni(io2_n), .io3_ni(io3_n),
    .blk1_ni(b1_n), .blk2_ni(b2_n), .blk3_ni(b3_n), .blk5_ni(b5_n),
    .a13_i(a13), .rom_hi_o(hi), .rom_ce_no(ce_n), .rom_oe_no(oe_n)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // blk: 0 none, 1..3 low block, 5 autostart, 6 autostart + low block 1
  task automatic step(input string tag, input int blk, input bit a, input bit r,
                      input bit s2, input bit s3, input int d, input bit rs);
    bit sl, s5;
    int e_hi;
    @(negedge clk);
    rst_n = rs; data = d[W-1:0]; rw = r; io2_n = !s2; io3_n = !s3; a13 = a;
    b1_n = !(blk == 1 || blk == 6); b2_n = !(blk == 2); b3_n = !(blk == 3);
    b5_n = !(blk == 5 || blk == 6);
    if (!rs) m_en = 0;
    #5;
    sl = (blk >= 1 && blk <= 3) || blk == 6;
    s5 = (blk == 5 || blk == 6);
    if (s5)      e_hi = m_en ? m_auto : int'(MENU);
    else if (sl) e_hi = (m_low < 0) ? -1 : (m_low ^ int'(a));
    else         e_hi = 0;
    if (e_hi >= 0) chk(tag, "rom_hi", int'(hi), e_hi);
    chk(tag, "ce_n", int'(ce_n), (sl || s5) ? 0 : 1);
    chk(tag, "oe_n", int'(oe_n), ((sl || s5) && r) ? 0 : 1);
    @(posedge clk);
    if (!r && s3) begin m_auto = d & 8'hFF; if (rs) m_en = 1; end
    if (!r && s2) m_low = d & 8'hFF;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R5 reset state idle, R1 menu during and after reset
    step("R5", 0, 0, 1, 0, 0, 0, 0);
    step("R1", 5, 1, 1, 0, 0, 0, 0);
    step("R1", 5, 1, 1, 0, 0, 0, 1);
    step("R1", 5, 0, 1, 0, 0, 0, 1);
    step("R5", 0, 1, 1, 0, 0, 8'hAA, 1);
    // R9: write cycle still shows menu; R6 oe high on write
    step("R9", 5, 1, 0, 0, 1, 8'h42, 1);
    step("R2", 5, 1, 1, 0, 0, 0, 1);
    // R4: read strobes have no effect
    step("R4", 5, 1, 1, 0, 1, 8'h99, 1);
    step("R4", 5, 1, 1, 0, 0, 0, 1);
    // R3: low block loading and 16K fold
    step("R3", 0, 0, 0, 1, 0, 8'h10, 1);
    step("R3", 1, 0, 1, 0, 0, 0, 1);
    step("R3", 2, 1, 1, 0, 0, 0, 1);
    step("R3", 3, 0, 1, 0, 0, 0, 1);
    step("R3", 1, 1, 0, 0, 0, 0, 1);
    step("R4", 1, 0, 1, 1, 0, 8'h77, 1);
    step("R4", 1, 0, 1, 0, 0, 0, 1);
    // R7: autostart register isolated and has priority
    step("R7", 6, 1, 1, 0, 0, 0, 1);
    step("R7", 5, 1, 1, 0, 0, 0, 1);
    // R2: written zero is honoured
    step("R2", 0, 0, 0, 0, 1, 8'h00, 1);
    step("R2", 5, 1, 1, 0, 0, 0, 1);
    // R8: reset reverts to menu, low cell survives
    step("R8", 0, 0, 1, 0, 0, 0, 0);
    step("R8", 5, 1, 1, 0, 0, 0, 1);
    step("R8", 2, 0, 1, 0, 0, 0, 1);
    step("R8", 0, 0, 0, 0, 1, 8'hFE, 1);
    step("R8", 5, 1, 1, 0, 0, 0, 1);
    // both registers in one write
    step("R3", 0, 0, 0, 1, 1, 8'h21, 1);
    step("R2", 5, 1, 1, 0, 0, 0, 1);
    step("R3", 3, 1, 1, 0, 0, 0, 1);
    step("R3", 0, 0, 0, 1, 0, 8'hFF, 1);
    step("R3", 1, 1, 1, 0, 0, 0, 1);
    step("R5", 0, 1, 1, 0, 0, 0, 1);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule